// File: doc/BRIEF.md
# CORDIC Complex Rotation Mixer

This block moves a complex input stream to baseband by turning each sample through a phase angle. The sine and cosine of that angle are never looked up in a table. A chain of shift-and-add micro-rotations, one per pipeline stage, rotates the sample vector directly. The angle comes from a phase accumulator that advances by a tuning word on every accepted sample. A 15-bit pseudo-noise value can optionally be added to the phase before truncation. This spreads the spurious tones caused by phase truncation across the band.

A real input is fed with a zero imaginary part. The angle is first folded into the right half-plane by negating both components when needed. A fixed multiply at the end removes the growth in magnitude that the micro-rotations introduce. The pipeline accepts one sample on every clock and returns results in order, each with a valid flag.

Top module: `cordic_mixer`

## Requirements
- R1: For each accepted sample, out_i + j·out_q equals (in_i + j·in_q)·exp(jθ), rounded, to within ±4 LSB per component. Here θ = 2π·idx/2^18, and idx is bits [31:14] of (phase + dither) taken modulo 2^32.
- R2: out_valid rises exactly 20 clock cycles after the edge that samples in_valid high (18 micro-rotation stages plus the fold and gain stages). Back-to-back inputs give back-to-back outputs in the same order, and no output appears without an input.
- R3: While rst_n is low, out_valid, out_i and out_q are 0. After release the phase is 0 and the dither register holds 1.
- R4: Any θ on the full circle is handled. θ is folded into [−π/2, π/2) by negating I and Q and subtracting π, and the residual angle after the last stage is near zero.
- R5: A real input (in_q = 0) produces out_i ≈ in_i·cos θ and out_q ≈ in_i·sin θ.
- R6: The phase adds freq_word modulo 2^32 once per accepted sample and holds when in_valid is low. The first sample after reset uses phase 0.
- R7: When dither_en is 1, the 15-bit dither register, zero-extended, is added to the phase before truncation; when it is 0, nothing is added. The register starts at 1 and steps once per accepted sample whatever dither_en is, with next = {s[13:0], s[14]^s[13]}.
- R8: Full-scale inputs, including −32768 in both components, are rotated without wrap-around. Every output component stays within ±49152.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| freq_word | input | 32 | Phase increment per accepted sample |
| dither_en | input | 1 | Adds the pseudo-noise value to the phase when 1 |
| in_valid | input | 1 | Input sample is present |
| in_i | input | 16 | Input real part, two's complement |
| in_q | input | 16 | Input imaginary part, two's complement |
| out_valid | output | 1 | Output sample is present |
| out_i | output | 17 | Output real part, two's complement |
| out_q | output | 17 | Output imaginary part, two's complement |

## Verification
The assertions assume that in_valid is held low throughout reset and that freq_word is stable in any cycle that samples in_valid high. The stimulus changes freq_word and dither_en only while the pipeline is idle and drives in_valid from a clean reset. The output bound assumes two's-complement inputs of at most 16 bits, which every test pattern respects, including the most negative corners. The directed patterns place angles in all four quadrants, at exact quarter turns and at arbitrary tuning words, with gaps between inputs and with the dither on and off.

// File: rtl/cordic_mixer_pkg.sv
`timescale 1ns/1ps
package cordic_mixer_pkg;

    // Arctangent of 2^-i as a fraction of a full turn, scaled by 2^frac_bits.
    function automatic int atan_code(input int i, input int frac_bits);
        real turn;
        turn = $atan(1.0 / (2.0 ** i)) / (2.0 * 3.14159265358979);
        return $rtoi(turn * (2.0 ** frac_bits) + 0.5);
    endfunction

    // Reciprocal of the accumulated micro-rotation gain, scaled by 2^gf.
    function automatic int inv_gain_code(input int iters, input int gf);
        real k;
        k = 1.0;
        for (int n = 0; n < iters; n++) begin
            k = k * $sqrt(1.0 + 1.0 / (2.0 ** (2 * n)));
        end
        return $rtoi((2.0 ** gf) / k + 0.5);
    endfunction

endpackage

// File: rtl/cm_phase_gen.sv
`timescale 1ns/1ps
module cm_phase_gen #(
    parameter int PW       = 32,
    parameter int AW       = 18,
    parameter int DITHER_W = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    input  logic [PW-1:0]       freq,
    input  logic                dither_en,
    output logic [AW-1:0]       theta,
    output logic [PW-1:0]       acc_o,
    output logic [DITHER_W-1:0] pn_o
);
    typedef struct packed {
        logic [PW-1:0]       acc;
        logic [DITHER_W-1:0] pn;
    } phase_t;

    localparam logic [DITHER_W-1:0] PN_SEED = DITHER_W'(1);

    phase_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            st_d.acc = st_q.acc + freq;
            st_d.pn  = {st_q.pn[DITHER_W-2:0], st_q.pn[DITHER_W-1] ^ st_q.pn[DITHER_W-2]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.acc <= '0;
            st_q.pn  <= PN_SEED;
        end else begin
            st_q <= st_d;
        end
    end

    assign theta = AW'((st_q.acc + (dither_en ? PW'(st_q.pn) : PW'(0))) >> (PW - AW));
    assign acc_o = st_q.acc;
    assign pn_o  = st_q.pn;
endmodule

// File: rtl/cm_quad_fold.sv
`timescale 1ns/1ps
module cm_quad_fold #(
    parameter int DW = 16,
    parameter int XW = 21,
    parameter int FB = 3,
    parameter int AW = 18,
    parameter int ZF = 4,
    parameter int ZW = 23
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vld_i,
    input  logic [DW-1:0]        re_i,
    input  logic [DW-1:0]        im_i,
    input  logic [AW-1:0]        theta_i,
    output logic                 vld_o,
    output logic signed [XW-1:0] x_o,
    output logic signed [XW-1:0] y_o,
    output logic signed [ZW-1:0] z_o
);
    typedef struct packed {
        logic                 vld;
        logic signed [XW-1:0] x;
        logic signed [XW-1:0] y;
        logic signed [ZW-1:0] z;
    } fold_t;

    fold_t st_d, st_q;

    always_comb begin
        logic                 flip;
        logic [AW-1:0]        tf;
        logic signed [XW-1:0] xe, ye;
        flip = theta_i[AW-1] ^ theta_i[AW-2];
        tf   = {theta_i[AW-1] ^ flip, theta_i[AW-2:0]};
        xe   = $signed({{(XW-DW-FB){re_i[DW-1]}}, re_i, {FB{1'b0}}});
        ye   = $signed({{(XW-DW-FB){im_i[DW-1]}}, im_i, {FB{1'b0}}});
        st_d.vld = vld_i;
        st_d.x   = flip ? -xe : xe;
        st_d.y   = flip ? -ye : ye;
        st_d.z   = $signed({{(ZW-AW-ZF){tf[AW-1]}}, tf, {ZF{1'b0}}});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o = st_q.vld;
    assign x_o   = st_q.x;
    assign y_o   = st_q.y;
    assign z_o   = st_q.z;
endmodule

// File: rtl/cm_cordic_stage.sv
`timescale 1ns/1ps
module cm_cordic_stage #(
    parameter int XW    = 21,
    parameter int ZW    = 23,
    parameter int SHIFT = 0,
    parameter int ATAN  = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vld_i,
    input  logic signed [XW-1:0] x_i,
    input  logic signed [XW-1:0] y_i,
    input  logic signed [ZW-1:0] z_i,
    output logic                 vld_o,
    output logic signed [XW-1:0] x_o,
    output logic signed [XW-1:0] y_o,
    output logic signed [ZW-1:0] z_o
);
    typedef struct packed {
        logic                 vld;
        logic signed [XW-1:0] x;
        logic signed [XW-1:0] y;
        logic signed [ZW-1:0] z;
    } rot_t;

    localparam logic signed [ZW-1:0] ANG = ZW'(ATAN);

    rot_t st_d, st_q;

    always_comb begin
        logic signed [XW-1:0] xs, ys;
        xs = x_i >>> SHIFT;
        ys = y_i >>> SHIFT;
        st_d.vld = vld_i;
        if (!z_i[ZW-1]) begin
            st_d.x = x_i - ys;
            st_d.y = y_i + xs;
            st_d.z = z_i - ANG;
        end else begin
            st_d.x = x_i + ys;
            st_d.y = y_i - xs;
            st_d.z = z_i + ANG;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o = st_q.vld;
    assign x_o   = st_q.x;
    assign y_o   = st_q.y;
    assign z_o   = st_q.z;
endmodule

// File: rtl/cm_gain.sv
`timescale 1ns/1ps
module cm_gain #(
    parameter int XW   = 21,
    parameter int OW   = 17,
    parameter int GF   = 16,
    parameter int FB   = 3,
    parameter int GAIN = 39797
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vld_i,
    input  logic signed [XW-1:0] x_i,
    input  logic signed [XW-1:0] y_i,
    output logic                 vld_o,
    output logic [OW-1:0]        re_o,
    output logic [OW-1:0]        im_o
);
    localparam int GW  = GF + 1;
    localparam int PRW = XW + GW;
    localparam int SH  = GF + FB;
    localparam logic signed [GW-1:0]  GC  = GW'(GAIN);
    localparam logic signed [PRW-1:0] RND = PRW'(1) <<< (SH - 1);

    typedef struct packed {
        logic          vld;
        logic [OW-1:0] re;
        logic [OW-1:0] im;
    } out_t;

    out_t st_d, st_q;

    always_comb begin
        logic signed [PRW-1:0] px, py, ge;
        ge = $signed({{XW{GC[GW-1]}}, GC});
        px = $signed({{GW{x_i[XW-1]}}, x_i}) * ge;
        py = $signed({{GW{y_i[XW-1]}}, y_i}) * ge;
        st_d.vld = vld_i;
        st_d.re  = OW'((px + RND) >>> SH);
        st_d.im  = OW'((py + RND) >>> SH);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o = st_q.vld;
    assign re_o  = st_q.re;
    assign im_o  = st_q.im;
endmodule

// File: rtl/cordic_mixer.sv
`timescale 1ns/1ps
module cordic_mixer #(
    parameter int DW       = 16,
    parameter int PW       = 32,
    parameter int AW       = 18,
    parameter int ITER     = 18,
    parameter int FB       = 3,
    parameter int ZF       = 4,
    parameter int GF       = 16,
    parameter int DITHER_W = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] freq_word,
    input  logic          dither_en,
    input  logic          in_valid,
    input  logic [DW-1:0] in_i,
    input  logic [DW-1:0] in_q,
    output logic          out_valid,
    output logic [DW:0]   out_i,
    output logic [DW:0]   out_q
);
    localparam int XW   = DW + 2 + FB;
    localparam int ZW   = AW + ZF + 1;
    localparam int OW   = DW + 1;
    localparam int GAIN = cordic_mixer_pkg::inv_gain_code(ITER, GF);

    logic [AW-1:0]        theta;
    logic [PW-1:0]        acc_w;
    logic [DITHER_W-1:0]  pn_w;
    logic                 s_vld [ITER+1];
    logic signed [XW-1:0] s_x   [ITER+1];
    logic signed [XW-1:0] s_y   [ITER+1];
    logic signed [ZW-1:0] s_z   [ITER+1];
    logic signed [ZW-1:0] fold_z;
    logic signed [ZW-1:0] resid_z;

    cm_phase_gen #(.PW(PW), .AW(AW), .DITHER_W(DITHER_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .adv(in_valid), .freq(freq_word),
        .dither_en(dither_en), .theta(theta), .acc_o(acc_w), .pn_o(pn_w)
    );

    cm_quad_fold #(.DW(DW), .XW(XW), .FB(FB), .AW(AW), .ZF(ZF), .ZW(ZW)) u_fold (
        .clk(clk), .rst_n(rst_n), .vld_i(in_valid), .re_i(in_i), .im_i(in_q),
        .theta_i(theta), .vld_o(s_vld[0]), .x_o(s_x[0]), .y_o(s_y[0]), .z_o(s_z[0])
    );

    for (genvar g = 0; g < ITER; g++) begin : g_stage
        cm_cordic_stage #(
            .XW(XW), .ZW(ZW), .SHIFT(g),
            .ATAN(cordic_mixer_pkg::atan_code(g, AW + ZF))
        ) u_stage (
            .clk(clk), .rst_n(rst_n),
            .vld_i(s_vld[g]),   .x_i(s_x[g]),   .y_i(s_y[g]),   .z_i(s_z[g]),
            .vld_o(s_vld[g+1]), .x_o(s_x[g+1]), .y_o(s_y[g+1]), .z_o(s_z[g+1])
        );
    end

    cm_gain #(.XW(XW), .OW(OW), .GF(GF), .FB(FB), .GAIN(GAIN)) u_gain (
        .clk(clk), .rst_n(rst_n), .vld_i(s_vld[ITER]), .x_i(s_x[ITER]), .y_i(s_y[ITER]),
        .vld_o(out_valid), .re_o(out_i), .im_o(out_q)
    );

    assign fold_z  = s_z[0];
    assign resid_z = s_z[ITER];
endmodule

// File: rtl/cm_checker.sv
`timescale 1ns/1ps
module cm_checker #(
    parameter int DW       = 16,
    parameter int PW       = 32,
    parameter int AW       = 18,
    parameter int ITER     = 18,
    parameter int ZF       = 4,
    parameter int DITHER_W = 15
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          in_valid,
    input logic [PW-1:0]                 freq_word,
    input logic [PW-1:0]                 acc,
    input logic [DITHER_W-1:0]           pn,
    input logic                          fold_vld,
    input logic signed [AW+ZF:0]         fold_z,
    input logic signed [AW+ZF:0]         resid_z,
    input logic                          out_valid,
    input logic [DW:0]                   out_i,
    input logic [DW:0]                   out_q
);
    localparam int LAT       = ITER + 2;
    localparam int ZW        = AW + ZF + 1;
    localparam int HALF_PI   = 2 ** (AW - 2 + ZF);
    localparam int RES_BOUND = 2 * cordic_mixer_pkg::atan_code(ITER - 1, AW + ZF) + ITER;
    localparam int OBOUND    = 3 * (2 ** (DW - 2));

    logic [LAT-1:0] vsh;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vsh <= '0;
        else        vsh <= {vsh[LAT-2:0], in_valid};
    end

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vsh[LAT-1]);

    assert_acc_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> acc == $past(acc) + $past(freq_word));

    assert_acc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(acc));

    assert_pn_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> pn == {$past(pn[DITHER_W-2:0]), $past(pn[DITHER_W-1] ^ pn[DITHER_W-2])});

    assert_pn_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pn != '0);

    assert_fold_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fold_vld |-> (fold_z >= ZW'(-HALF_PI)) && (fold_z < ZW'(HALF_PI)));

    assert_residual_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(resid_z) <= ZW'(RES_BOUND) && $past(resid_z) >= ZW'(-RES_BOUND));

    assert_out_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($signed(out_i) <= OBOUND) && ($signed(out_i) >= -OBOUND)
                   && ($signed(out_q) <= OBOUND) && ($signed(out_q) >= -OBOUND));
endmodule

bind cordic_mixer cm_checker #(
    .DW(DW), .PW(PW), .AW(AW), .ITER(ITER), .ZF(ZF), .DITHER_W(DITHER_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .freq_word(freq_word),
    .acc(acc_w), .pn(pn_w), .fold_vld(s_vld[0]), .fold_z(fold_z), .resid_z(resid_z),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
);

// File: tb/tb_cordic_mixer.sv
`timescale 1ns/1ps
module tb_cordic_mixer;
    localparam int  LAT   = 20;
    localparam int  TOL   = 4;
    localparam int  BOUND = 49152;
    localparam real PI    = 3.14159265358979;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] freq_word = '0;
    logic        dither_en = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_i = '0;
    logic [15:0] in_q = '0;
    logic        out_valid;
    logic [16:0] out_i, out_q;

    cordic_mixer dut (
        .clk(clk), .rst_n(rst_n), .freq_word(freq_word), .dither_en(dither_en),
        .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    typedef struct {
        int     ei;
        int     eq;
        longint stamp;
    } exp_t;

    int          n_tests = 0;
    int          n_fail  = 0;
    longint      cyc     = 0;
    string       tag     = "R3";
    exp_t        expq[$];
    int          cap_i[$];
    int          cap_q[$];
    logic [31:0] m_acc;
    logic [14:0] m_pn;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int rnd(input real r);
        return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Output monitor: compares each result with the model, in order.
    always @(negedge clk) begin
        int   ai, aq;
        exp_t e;
        if (rst_n && out_valid) begin
            ai = $signed(out_i);
            aq = $signed(out_q);
            cap_i.push_back(ai);
            cap_q.push_back(aq);
            if (expq.size() == 0) begin
                chk(1'b0, "R2", "output without input", ai, 0);
            end else begin
                e = expq.pop_front();
                chk(iabs(ai - e.ei) <= TOL, tag, "real part", ai, e.ei);
                chk(iabs(aq - e.eq) <= TOL, tag, "imag part", aq, e.eq);
                chk(int'(cyc - e.stamp) == LAT, "R2", "latency", int'(cyc - e.stamp), LAT);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input int i, input int q);
        logic [31:0] s;
        int          idx;
        real         a;
        exp_t        e;
        s   = m_acc + (dither_en ? {17'd0, m_pn} : 32'd0);
        idx = int'(s >> 14);
        a   = 2.0 * PI * real'(idx) / 262144.0;
        e.ei    = rnd(real'(i) * $cos(a) - real'(q) * $sin(a));
        e.eq    = rnd(real'(i) * $sin(a) + real'(q) * $cos(a));
        e.stamp = cyc;
        expq.push_back(e);
        in_valid = 1'b1;
        in_i     = 16'(i);
        in_q     = 16'(q);
        m_acc    = m_acc + freq_word;
        m_pn     = {m_pn[13:0], m_pn[14] ^ m_pn[13]};
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        idle(LAT + 3);
        chk(expq.size() == 0, tag, "pending outputs", expq.size(), 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle(3);
        chk(out_valid == 1'b0, "R3", "out_valid in reset", int'(out_valid), 0);
        chk(out_i == '0 && out_q == '0, "R3", "data in reset", int'(out_i), 0);
        rst_n = 1'b1;
        m_acc = '0;
        m_pn  = 15'h0001;
        expq.delete();
        cap_i.delete();
        cap_q.delete();
        idle(2);
        chk(out_valid == 1'b0, "R3", "out_valid after release", int'(out_valid), 0);
    endtask

    task automatic t_identity();
        tag = "R1"; freq_word = 32'd0; dither_en = 1'b0;
        do_reset();
        send(1000, -2000); send(32767, 0); send(-5000, 12345); send(0, -32768);
        drain();
    endtask

    task automatic t_quadrants();
        tag = "R4"; freq_word = 32'h4000_0000; dither_en = 1'b0;
        do_reset();
        for (int k = 0; k < 8; k++) send(20000, 5000);
        drain();
        freq_word = 32'h7FF0_0000;
        do_reset();
        for (int k = 0; k < 12; k++) send(-12000, 17000);
        drain();
    endtask

    task automatic t_sweep();
        tag = "R1"; freq_word = 32'h1357_9BDF; dither_en = 1'b0;
        do_reset();
        for (int k = 0; k < 40; k++) send((k * 7919) % 60000 - 30000, (k * 4451) % 50000 - 25000);
        drain();
    endtask

    task automatic t_real();
        tag = "R5"; freq_word = 32'h0A3D_70A4; dither_en = 1'b0;
        do_reset();
        for (int k = 0; k < 16; k++) send(30000 - k * 3500, 0);
        drain();
    endtask

    task automatic t_fullscale();
        tag = "R8"; freq_word = 32'h2000_0000; dither_en = 1'b0;
        do_reset();
        for (int k = 0; k < 4; k++) begin
            send(-32768, -32768); send(32767, 32767); send(-32768, 32767); send(32767, -32768);
        end
        drain();
        foreach (cap_i[n]) begin
            chk(iabs(cap_i[n]) <= BOUND && iabs(cap_q[n]) <= BOUND, "R8", "output bound",
                iabs(cap_i[n]), BOUND);
        end
    endtask

    task automatic t_gaps();
        tag = "R6"; freq_word = 32'h0ABC_1234; dither_en = 1'b0;
        do_reset();
        for (int k = 0; k < 10; k++) begin
            send(25000, -9000);
            idle(k % 4);
        end
        drain();
    endtask

    task automatic t_backtoback();
        tag = "R2"; freq_word = 32'hF123_4567; dither_en = 1'b0;
        do_reset();
        for (int k = 0; k < 30; k++) send(k * 1000 - 15000, 14000 - k * 900);
        drain();
        chk(cap_i.size() == 30, "R2", "output count", cap_i.size(), 30);
    endtask

    task automatic t_dither();
        int off_i[48];
        int off_q[48];
        int diffs;
        tag = "R7"; freq_word = 32'h0123_4567; dither_en = 1'b0;
        do_reset();
        for (int k = 0; k < 48; k++) send(30000, -20000);
        drain();
        for (int k = 0; k < 48; k++) begin
            off_i[k] = (k < cap_i.size()) ? cap_i[k] : 0;
            off_q[k] = (k < cap_q.size()) ? cap_q[k] : 0;
        end
        dither_en = 1'b1;
        do_reset();
        for (int k = 0; k < 48; k++) send(30000, -20000);
        drain();
        diffs = 0;
        for (int k = 0; k < 48 && k < cap_i.size(); k++) begin
            if (cap_i[k] != off_i[k] || cap_q[k] != off_q[k]) diffs++;
        end
        chk(diffs > 0, "R7", "dither changes outputs", diffs, 1);
        dither_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        t_identity();
        t_quadrants();
        t_sweep();
        t_real();
        t_fullscale();
        t_gaps();
        t_backtoback();
        t_dither();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule